// File: doc/BRIEF.md
# CPU Access Port with Control Register and Memory Window Decoder

This block sits between a byte-wide microprocessor bus and the three memories of a time-slot switch: a data memory that only the switch writes, and a low and a high connection memory. The bus has a six-bit address. Half of that space reaches a single control register. The other half is a 32-entry window into one memory. Fields of the control register choose which memory the window shows and which of eight stream subsections it covers.

A split mode sends every windowed read to the data memory and every windowed write to the low connection memory. Software can then update connections and watch switched traffic without rewriting the control register between accesses. The block produces the memory address, per-memory read strobes and single-cycle write pulses, and a registered read-back byte. It also exposes the message-enable bit to the switching datapath.

Top module: `cpu_port_dec`

## Requirements
- R1: After reset the control register holds 0x00, `cpu_rdata` is 0x00, `msg_en` is 0 and no write pulse is active.
- R2: An access with `cpu_addr[5]`=0 targets the control register. A write stores the byte and raises no memory write pulse. A read returns the stored byte with bit 5 forced to 0. The layout is: bit 7 split, bit 6 message enable, bit 5 unused, bits 4:3 memory select, bits 2:0 stream.
- R3: For an access with `cpu_addr[5]`=1, `mem_addr` equals {stream field, `cpu_addr[4:0]`}.
- R4: With split=0 and memory select 2'b10, a windowed write pulses `cml_we` only, and a windowed read returns `cml_rdata`.
- R5: With split=0 and memory select 2'b11, a windowed write pulses `cmh_we` only, and a windowed read returns `cmh_rdata`.
- R6: With split=0 and memory select 2'b01, a windowed read returns `dm_rdata`. A windowed write raises no write pulse, so neither connection memory changes.
- R7: With split=0 and memory select 2'b00, a windowed write raises no write pulse, and a windowed read returns 0x00.
- R8: With split=1, whatever the memory select, windowed reads return `dm_rdata` and windowed writes pulse `cml_we` only.
- R9: A write pulse lasts one clock for each continuous assertion of `cpu_cs` and `cpu_wr` together, in the first cycle of that assertion. None occurs while `cpu_cs` is low.
- R10: Read data is registered. It takes its new value one clock after a cycle with `cpu_cs` and `cpu_rd` high, and it holds that value until the next such read.
- R11: `msg_en` follows bit 6 of the control register from the clock after the register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_cs | input | 1 | Chip select, active high |
| cpu_rd | input | 1 | Read strobe, active high |
| cpu_wr | input | 1 | Write strobe, active high |
| cpu_addr | input | 6 | Bit 5 picks window (1) or control register (0); bits 4:0 give the channel |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| mem_addr | output | 8 | {stream, channel} address to all memories |
| mem_wdata | output | 8 | Write data toward the connection memories |
| dm_re | output | 1 | Data memory read strobe |
| dm_rdata | input | 8 | Data memory read value for `mem_addr` |
| cml_re | output | 1 | Low connection memory read strobe |
| cml_we | output | 1 | Low connection memory write pulse |
| cml_rdata | input | 8 | Low connection memory read value |
| cmh_re | output | 1 | High connection memory read strobe |
| cmh_we | output | 1 | High connection memory write pulse |
| cmh_rdata | input | 8 | High connection memory read value |
| msg_en | output | 1 | Message-enable bit of the control register |

## Verification
The address, the read strobes and the write pulses are combinational from the bus inputs. The bench therefore samples them one nanosecond after it drives the inputs at the falling edge, before the rising edge that completes the access. Read data and control register contents pass through one register. For these, the bench deasserts the strobes at the next falling edge and samples there, which is one clock after the read cycle. The bench also samples once before that edge, to confirm that the old value still holds while the read is in progress.

// File: rtl/cpu_port_pkg.sv
package cpu_port_pkg;
    localparam int CPU_DW   = 8;
    localparam int CHAN_W   = 5;
    localparam int STREAM_W = 3;
    localparam int CPU_AW   = CHAN_W + 1;
    localparam int MADDR_W  = STREAM_W + CHAN_W;

    typedef enum logic [1:0] {
        MSEL_NONE   = 2'b00,
        MSEL_DATA   = 2'b01,
        MSEL_CONNLO = 2'b10,
        MSEL_CONNHI = 2'b11
    } msel_e;

    typedef struct packed {
        logic                split;
        logic                msg;
        logic                rsvd;
        msel_e               msel;
        logic [STREAM_W-1:0] stream;
    } ctrl_t;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_CTRL,
        TGT_DM,
        TGT_CML,
        TGT_CMH
    } tgt_e;
endpackage

// File: rtl/cpu_ctrl_reg.sv
module cpu_ctrl_reg
    import cpu_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_active,
    input  logic              ctrl_hit,
    input  logic [CPU_DW-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic              wr_first
);
    typedef struct packed {
        ctrl_t ctrl;
        logic  seen;
    } creg_state_t;

    creg_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.seen = wr_active;
        wr_first  = wr_active && !st_q.seen;
        if (wr_first && ctrl_hit) begin
            st_d.ctrl      = ctrl_t'(wdata);
            st_d.ctrl.rsvd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ctrl_q = st_q.ctrl;

    // R2
    ctrl_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_first && ctrl_hit) |=> $stable(ctrl_q));

    // R9
    first_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_first |=> !wr_first);
endmodule

// File: rtl/cpu_acc_decode.sv
module cpu_acc_decode
    import cpu_port_pkg::*;
(
    input  logic                cs,
    input  logic                rd,
    input  logic                wr_first,
    input  logic [CPU_AW-1:0]   addr,
    input  logic                split,
    input  msel_e               msel,
    input  logic [STREAM_W-1:0] stream,
    output logic                ctrl_hit,
    output tgt_e                rd_tgt,
    output logic [MADDR_W-1:0]  mem_addr,
    output logic                dm_re,
    output logic                cml_re,
    output logic                cmh_re,
    output logic                cml_we,
    output logic                cmh_we
);
    tgt_e wr_tgt;
    logic rd_act;

    always_comb begin
        ctrl_hit = !addr[CPU_AW-1];
        rd_tgt   = TGT_NONE;
        wr_tgt   = TGT_NONE;
        if (ctrl_hit) begin
            rd_tgt = TGT_CTRL;
            wr_tgt = TGT_CTRL;
        end else if (split) begin
            rd_tgt = TGT_DM;
            wr_tgt = TGT_CML;
        end else begin
            unique case (msel)
                MSEL_DATA:   begin rd_tgt = TGT_DM;  wr_tgt = TGT_NONE; end
                MSEL_CONNLO: begin rd_tgt = TGT_CML; wr_tgt = TGT_CML;  end
                MSEL_CONNHI: begin rd_tgt = TGT_CMH; wr_tgt = TGT_CMH;  end
                default:     begin rd_tgt = TGT_NONE; wr_tgt = TGT_NONE; end
            endcase
        end
    end

    assign rd_act   = cs && rd;
    assign mem_addr = {stream, addr[CHAN_W-1:0]};
    assign dm_re    = rd_act && (rd_tgt == TGT_DM);
    assign cml_re   = rd_act && (rd_tgt == TGT_CML);
    assign cmh_re   = rd_act && (rd_tgt == TGT_CMH);
    assign cml_we   = wr_first && (wr_tgt == TGT_CML);
    assign cmh_we   = wr_first && (wr_tgt == TGT_CMH);
endmodule

// File: rtl/cpu_rd_capture.sv
module cpu_rd_capture
    import cpu_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_act,
    input  tgt_e              rd_tgt,
    input  ctrl_t             ctrl,
    input  logic [CPU_DW-1:0] dm_rdata,
    input  logic [CPU_DW-1:0] cml_rdata,
    input  logic [CPU_DW-1:0] cmh_rdata,
    output logic [CPU_DW-1:0] rdata
);
    typedef struct packed {
        logic [CPU_DW-1:0] data;
    } rcap_state_t;

    rcap_state_t st_d, st_q;
    ctrl_t       ctrl_view;

    always_comb begin
        ctrl_view      = ctrl;
        ctrl_view.rsvd = 1'b0;
        st_d           = st_q;
        if (rd_act) begin
            unique case (rd_tgt)
                TGT_CTRL: st_d.data = CPU_DW'(ctrl_view);
                TGT_DM:   st_d.data = dm_rdata;
                TGT_CML:  st_d.data = cml_rdata;
                TGT_CMH:  st_d.data = cmh_rdata;
                default:  st_d.data = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.data;

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> $stable(rdata));

    // R2
    rsvd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && rd_tgt == TGT_CTRL) |=> !rdata[5]);
endmodule

// File: rtl/cpu_port_dec.sv
module cpu_port_dec
    import cpu_port_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_cs,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic [CPU_DW-1:0]  cpu_wdata,
    output logic [CPU_DW-1:0]  cpu_rdata,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [CPU_DW-1:0]  mem_wdata,
    output logic               dm_re,
    input  logic [CPU_DW-1:0]  dm_rdata,
    output logic               cml_re,
    output logic               cml_we,
    input  logic [CPU_DW-1:0]  cml_rdata,
    output logic               cmh_re,
    output logic               cmh_we,
    input  logic [CPU_DW-1:0]  cmh_rdata,
    output logic               msg_en
);
    ctrl_t ctrl_q;
    logic  wr_first;
    logic  ctrl_hit;
    tgt_e  rd_tgt;
    logic  wr_act;
    logic  rd_act;

    assign wr_act    = cpu_cs && cpu_wr;
    assign rd_act    = cpu_cs && cpu_rd;
    assign mem_wdata = cpu_wdata;
    assign msg_en    = ctrl_q.msg;

    cpu_ctrl_reg u_creg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_active (wr_act),
        .ctrl_hit  (ctrl_hit),
        .wdata     (cpu_wdata),
        .ctrl_q    (ctrl_q),
        .wr_first  (wr_first)
    );

    cpu_acc_decode u_dec (
        .cs       (cpu_cs),
        .rd       (cpu_rd),
        .wr_first (wr_first),
        .addr     (cpu_addr),
        .split    (ctrl_q.split),
        .msel     (ctrl_q.msel),
        .stream   (ctrl_q.stream),
        .ctrl_hit (ctrl_hit),
        .rd_tgt   (rd_tgt),
        .mem_addr (mem_addr),
        .dm_re    (dm_re),
        .cml_re   (cml_re),
        .cmh_re   (cmh_re),
        .cml_we   (cml_we),
        .cmh_we   (cmh_we)
    );

    cpu_rd_capture u_rcap (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_act    (rd_act),
        .rd_tgt    (rd_tgt),
        .ctrl      (ctrl_q),
        .dm_rdata  (dm_rdata),
        .cml_rdata (cml_rdata),
        .cmh_rdata (cmh_rdata),
        .rdata     (cpu_rdata)
    );

    // R9
    we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cml_we, cmh_we}));

    // R9
    we_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cml_we || cmh_we) |-> (cpu_cs && cpu_wr));

    // R9
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cml_we || cmh_we) |=> !(cml_we || cmh_we));

    // R2
    ctrl_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[CPU_AW-1] |-> !(cml_we || cmh_we));

    // R3
    chan_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_addr[CPU_AW-1]) |-> (mem_addr[CHAN_W-1:0] == cpu_addr[CHAN_W-1:0]));

    // R8
    split_no_cmh_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.split |-> !(cmh_we || cmh_re || cml_re));
endmodule

// File: tb/tb_cpu_port_dec.sv
module tb_cpu_port_dec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
    logic [5:0] cpu_addr = '0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata, mem_addr, mem_wdata;
    logic       dm_re, cml_re, cml_we, cmh_re, cmh_we, msg_en;
    logic [7:0] dm_rdata, cml_rdata, cmh_rdata;
    logic [7:0] cml_mem [256];
    logic [7:0] cmh_mem [256];
    int         total = 0, bad = 0;

    always #4 clk = ~clk;

    assign dm_rdata  = mem_addr ^ 8'h5A;
    assign cml_rdata = cml_mem[mem_addr];
    assign cmh_rdata = cmh_mem[mem_addr];

    always @(posedge clk) begin
        if (cml_we) cml_mem[mem_addr] <= mem_wdata;
        if (cmh_we) cmh_mem[mem_addr] <= mem_wdata;
    end

    cpu_port_dec dut (
        .clk(clk), .rst_n(rst_n), .cpu_cs(cpu_cs), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dm_re(dm_re), .dm_rdata(dm_rdata),
        .cml_re(cml_re), .cml_we(cml_we), .cml_rdata(cml_rdata),
        .cmh_re(cmh_re), .cmh_we(cmh_we), .cmh_rdata(cmh_rdata), .msg_en(msg_en)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one write cycle; we/address sampled before the capturing edge
    task automatic bus_write(input logic [5:0] a, input logic [7:0] d,
                             output logic wl, output logic wh, output logic [7:0] ma);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        #1;
        wl = cml_we; wh = cmh_we; ma = mem_addr;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = a;
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        d = cpu_rdata;
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        logic wl, wh; logic [7:0] ma;
        bus_write(6'h00, v, wl, wh, ma);
    endtask

    task automatic t_reset();
        check("R1 rdata", cpu_rdata, 8'h00);
        check("R1 msg_en", {7'd0, msg_en}, 8'h00);
        check("R1 we", {6'd0, cml_we, cmh_we}, 8'h00);
        begin
            logic [7:0] r;
            bus_read(6'h00, r);
            check("R1 ctrl", r, 8'h00);
        end
    endtask

    task automatic t_ctrl();
        logic wl, wh; logic [7:0] ma, r;
        bus_write(6'h00, 8'hFF, wl, wh, ma);
        check("R2 no we on ctrl write", {6'd0, wl, wh}, 8'h00);
        bus_read(6'h1F, r);
        check("R2 ctrl readback bit5 zero", r, 8'hDF);
        check("R11 msg_en set", {7'd0, msg_en}, 8'h01);
        set_ctrl(8'h00);
        check("R11 msg_en clear", {7'd0, msg_en}, 8'h00);
    endtask

    task automatic t_cml();
        logic wl, wh; logic [7:0] ma, r;
        set_ctrl(8'h15);
        bus_write(6'h27, 8'h3C, wl, wh, ma);
        check("R4 cml_we", {6'd0, wl, wh}, 8'h02);
        check("R3 mem_addr", ma, 8'hA7);
        bus_read(6'h27, r);
        check("R4 cml readback", r, 8'h3C);
    endtask

    task automatic t_cmh();
        logic wl, wh; logic [7:0] ma, r;
        set_ctrl(8'h1A);
        bus_write(6'h3F, 8'h81, wl, wh, ma);
        check("R5 cmh_we", {6'd0, wl, wh}, 8'h01);
        check("R3 mem_addr", ma, 8'h5F);
        bus_read(6'h3F, r);
        check("R5 cmh readback", r, 8'h81);
        set_ctrl(8'h12);
        bus_read(6'h3F, r);
        check("R5 cml untouched", r, 8'h00);
    endtask

    task automatic t_dm();
        logic wl, wh; logic [7:0] ma, r;
        set_ctrl(8'h0B);
        bus_write(6'h24, 8'hEE, wl, wh, ma);
        check("R6 dm write ignored", {6'd0, wl, wh}, 8'h00);
        bus_read(6'h24, r);
        check("R6 dm read", r, 8'h3E);
        set_ctrl(8'h13);
        bus_read(6'h24, r);
        check("R6 cml unchanged", r, 8'h00);
    endtask

    task automatic t_none();
        logic wl, wh; logic [7:0] ma, r;
        set_ctrl(8'h01);
        bus_write(6'h21, 8'h99, wl, wh, ma);
        check("R7 no we", {6'd0, wl, wh}, 8'h00);
        bus_read(6'h21, r);
        check("R7 read zero", r, 8'h00);
    endtask

    task automatic t_split();
        logic wl, wh; logic [7:0] ma, r;
        set_ctrl(8'h9E);
        bus_write(6'h29, 8'h77, wl, wh, ma);
        check("R8 split write to cml", {6'd0, wl, wh}, 8'h02);
        check("R8 split addr", ma, 8'hC9);
        bus_read(6'h29, r);
        check("R8 split read dm", r, 8'h93);
        set_ctrl(8'h86);
        bus_write(6'h2A, 8'h55, wl, wh, ma);
        check("R8 split msel00 write", {6'd0, wl, wh}, 8'h02);
        set_ctrl(8'h16);
        bus_read(6'h2A, r);
        check("R8 cml holds 55", r, 8'h55);
        bus_read(6'h29, r);
        check("R8 cml holds 77", r, 8'h77);
    endtask

    task automatic t_pulse();
        int cnt = 0;
        set_ctrl(8'h14);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_wr = 1'b1; cpu_addr = 6'h23; cpu_wdata = 8'h42;
        for (int i = 0; i < 3; i++) begin
            #1;
            if (cml_we) cnt++;
            @(negedge clk);
        end
        cpu_cs = 1'b0; cpu_wr = 1'b0;
        check("R9 one pulse per hold", 8'(cnt), 8'd1);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = 6'h23;
        #1;
        check("R9 no we without cs", {6'd0, cml_we, cmh_we}, 8'h00);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic t_rdhold();
        logic [7:0] r;
        set_ctrl(8'h16);
        bus_read(6'h29, r);
        check("R10 first read", r, 8'h77);
        repeat (3) @(negedge clk);
        check("R10 hold while idle", cpu_rdata, 8'h77);
        @(negedge clk);
        cpu_cs = 1'b1; cpu_rd = 1'b1; cpu_addr = 6'h2A;
        #1;
        check("R10 old value before edge", cpu_rdata, 8'h77);
        @(negedge clk);
        cpu_cs = 1'b0; cpu_rd = 1'b0;
        check("R10 new value after edge", cpu_rdata, 8'h55);
    endtask

    initial begin
        #(8 * 200000);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            cml_mem[i] = 8'h00;
            cmh_mem[i] = 8'h00;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_cml();
        t_cmh();
        t_dm();
        t_none();
        t_split();
        t_pulse();
        t_rdhold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule